// File: doc/BRIEF.md
# Strobe-Driven Burst Access Controller

This controller gives a processor random access to a two-bank line memory through row and column strobes on a shared address bus. Both strobes are active low. A falling row strobe opens a row. The first falling column strobe that follows sets the start column. After that, each further falling column strobe moves one word. Eight words make up a burst, and the column wraps inside the line. Write words are gathered in a buffer, and the whole burst is handed to storage as one commit when the row strobe rises.

A column strobe that falls while the row strobe is still high starts a refresh instead. The refreshed row comes from an internal counter, and the address bus is ignored. The strobes are sampled by the system clock, so every strobe edge acts two clock edges after it reaches the pins. A wait output tells the processor when it may move data. The whole block is active only while the mode input is high. While the mode input is low, the block asks the rest of the memory to run its own self-refresh.

Top module: `bca_burst_ctrl`

## Requirements
- R1: After reset, wait_o is 1, and dq_oe_o, commit_o and ref_o are all 0.
- R2: A falling row strobe while the column strobe is high captures the row. The first falling column strobe after the row wait captures the column. After each of these two captures, wait_o is 0 for exactly WAIT_CYC clock cycles. Outside these two windows, wait_o is 1.
- R3: The start column is the column address modulo LINE_W. The next 8 falling column strobes each transfer one word at columns start, start+1 and so on, wrapping from LINE_W-1 to 0.
- R4: A cycle is a write when either bank enable is low at the row capture. The bank is 0 when lwe_ni is low and 1 when only uwe_ni is low. If both enables are low, the design writes bank 0.
- R5: In a read cycle, row address bit 9 selects the bank (0 means bank 0) and bits 8:0 give the row. Each read beat loads dq_o with rdata_i for the current column.
- R6: dq_oe_o is 1 only during the data phase of a read cycle, while re_ni is low and mode_i is high.
- R7: When the row strobe rises after all 8 write beats, commit_o pulses for one cycle. It carries the bank, the row, the start column and the words, with word i in bits [12*i+11:12*i]. A write burst cut short by a rising row strobe produces no commit.
- R8: A falling column strobe before a falling row strobe produces a one-cycle ref_o pulse. ref_row_o carries the counter value, and the counter steps from 0 to 289 and then wraps to 0. The address bus has no effect on the refreshed row.
- R9: While mode_i is low, the strobes are ignored and selfref_en_o is 1. While mode_i is high, selfref_en_o is 0.
- R10: A falling column strobe during the column wait transfers nothing and does not move the column.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | 1 | 1 enables block access |
| ras_ni | input | 1 | Row strobe, active low |
| cas_ni | input | 1 | Column strobe, active low |
| addr_i | input | 10 | Multiplexed row/column address |
| lwe_ni | input | 1 | Lower bank write enable, active low |
| uwe_ni | input | 1 | Upper bank write enable, active low |
| re_ni | input | 1 | Read output enable, active low |
| dq_i | input | 12 | Write data from the bus |
| dq_o | output | 12 | Read data to the bus |
| dq_oe_o | output | 1 | Bus drive enable |
| wait_o | output | 1 | 0 while an address is being set up |
| selfref_en_o | output | 1 | Allows self-refresh in the rest of the memory |
| rd_bank_o | output | 1 | Read bank to storage |
| rd_row_o | output | 9 | Read row to storage |
| rd_col_o | output | 10 | Read column to storage |
| rdata_i | input | 12 | Word returned by storage |
| commit_o | output | 1 | Write burst commit pulse |
| commit_bank_o | output | 1 | Commit bank |
| commit_row_o | output | 9 | Commit row |
| commit_col_o | output | 10 | Commit start column |
| commit_data_o | output | 96 | Eight burst words |
| ref_o | output | 1 | Refresh pulse |
| ref_row_o | output | 9 | Row being refreshed |

## Verification
The hardest cases to reach are the ones where the timing of the strobes matters: a column strobe that falls during the column wait, and a row strobe that rises before the eighth beat. The stimulus places these edges at chosen clock offsets from the capture edges. A behavioural model then shows whether a beat or a commit leaked through. The refresh wrap needs the counter to pass 289, so the bench runs more than 290 refresh cycles back to back, each with a changing address. Start columns near the end of the line force the column to wrap in the middle of a burst.

// File: rtl/bca_pkg.sv
package bca_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_ROWW, ST_ACT, ST_COLW, ST_BURST, ST_DONE, ST_REFR
  } bca_state_e;
endpackage

// File: rtl/bca_strobe_smp.sv
module bca_strobe_smp #(
  parameter int N = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] strb_i,
  output logic [N-1:0] lvl_o,
  output logic [N-1:0] fall_o,
  output logic [N-1:0] rise_o
);
  for (genvar g = 0; g < N; g++) begin : g_bit
    logic s1_q, s2_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        s1_q <= 1'b1;
        s2_q <= 1'b1;
      end else begin
        s1_q <= strb_i[g];
        s2_q <= s1_q;
      end
    end
    assign lvl_o[g]  = s1_q;
    assign fall_o[g] = s2_q & ~s1_q;
    assign rise_o[g] = ~s2_q & s1_q;
  end
endmodule

// File: rtl/bca_wait_tmr.sv
module bca_wait_tmr #(
  parameter int WAIT_CYC = 4,
  localparam int TW = (WAIT_CYC > 1) ? $clog2(WAIT_CYC) : 1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  input  logic en_i,
  output logic done_o
);
  logic [TW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (load_i)            cnt_q <= TW'(WAIT_CYC - 1);
    else if (en_i && !done_o)   cnt_q <= cnt_q - 1'b1;
  end
  assign done_o = (cnt_q == '0);

  assert_wait_step_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !load_i && !done_o) |=> (cnt_q == $past(cnt_q) - 1'b1));
endmodule

// File: rtl/bca_ref_ctr.sv
module bca_ref_ctr #(
  parameter int REF_ROWS = 290,
  localparam int RW = $clog2(REF_ROWS)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          inc_i,
  output logic [RW-1:0] cnt_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_o <= '0;
    else if (inc_i)  cnt_o <= (cnt_o == RW'(REF_ROWS - 1)) ? '0 : cnt_o + 1'b1;
  end

  assert_ref_range_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_o < RW'(REF_ROWS));
  assert_ref_wrap_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inc_i && cnt_o == RW'(REF_ROWS - 1)) |=> (cnt_o == '0));
endmodule

// File: rtl/bca_col_step.sv
module bca_col_step #(
  parameter int LINE_W    = 768,
  parameter int CW        = 10,
  parameter int BURST_LEN = 8,
  localparam int BW = $clog2(BURST_LEN)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [CW-1:0] start_i,
  input  logic          step_i,
  output logic [CW-1:0] col_o,
  output logic          last_o
);
  logic [BW-1:0] beat_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      col_o  <= '0;
      beat_q <= '0;
    end else if (load_i) begin
      col_o  <= start_i;
      beat_q <= '0;
    end else if (step_i) begin
      col_o  <= (col_o == CW'(LINE_W - 1)) ? '0 : col_o + 1'b1;
      beat_q <= beat_q + 1'b1;
    end
  end
  assign last_o = (beat_q == BW'(BURST_LEN - 1));

  assert_col_range_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    col_o < CW'(LINE_W));
endmodule

// File: rtl/bca_burst_ctrl.sv
module bca_burst_ctrl
  import bca_pkg::*;
#(
  parameter int ADDR_W    = 10,
  parameter int DATA_W    = 12,
  parameter int LINE_W    = 768,
  parameter int REF_ROWS  = 290,
  parameter int BURST_LEN = 8,
  parameter int WAIT_CYC  = 4,
  localparam int ROW_W = ADDR_W - 1,
  localparam int RW    = $clog2(REF_ROWS),
  localparam int BW    = $clog2(BURST_LEN)
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        mode_i,
  input  logic                        ras_ni,
  input  logic                        cas_ni,
  input  logic [ADDR_W-1:0]           addr_i,
  input  logic                        lwe_ni,
  input  logic                        uwe_ni,
  input  logic                        re_ni,
  input  logic [DATA_W-1:0]           dq_i,
  output logic [DATA_W-1:0]           dq_o,
  output logic                        dq_oe_o,
  output logic                        wait_o,
  output logic                        selfref_en_o,
  output logic                        rd_bank_o,
  output logic [ROW_W-1:0]            rd_row_o,
  output logic [ADDR_W-1:0]           rd_col_o,
  input  logic [DATA_W-1:0]           rdata_i,
  output logic                        commit_o,
  output logic                        commit_bank_o,
  output logic [ROW_W-1:0]            commit_row_o,
  output logic [ADDR_W-1:0]           commit_col_o,
  output logic [BURST_LEN*DATA_W-1:0] commit_data_o,
  output logic                        ref_o,
  output logic [RW-1:0]               ref_row_o
);
  logic [1:0] lvl, fall, rise;
  bca_strobe_smp #(.N(2)) u_smp (
    .clk_i(clk_i), .rst_ni(rst_ni), .strb_i({cas_ni, ras_ni}),
    .lvl_o(lvl), .fall_o(fall), .rise_o(rise)
  );
  wire ras_fall = fall[0];
  wire ras_rise = rise[0];
  wire cas_fall = fall[1];
  wire cas_lvl  = lvl[1];

  // bus side sampled alongside the strobes so capture aligns with edge detection
  logic [ADDR_W-1:0] addr_s;
  logic [DATA_W-1:0] dq_s;
  logic              lwe_s, uwe_s;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_s <= '0;
      dq_s   <= '0;
      lwe_s  <= 1'b1;
      uwe_s  <= 1'b1;
    end else begin
      addr_s <= addr_i;
      dq_s   <= dq_i;
      lwe_s  <= lwe_ni;
      uwe_s  <= uwe_ni;
    end
  end

  bca_state_e st_q, st_d;
  logic tmr_load, tmr_done, col_load, col_step, col_last, ref_inc, cap_row, do_commit;
  logic [ADDR_W-1:0] col, col_start;
  logic [RW-1:0]     ref_cnt;

  assign col_start = (addr_s >= ADDR_W'(LINE_W)) ? addr_s - ADDR_W'(LINE_W) : addr_s;

  bca_wait_tmr #(.WAIT_CYC(WAIT_CYC)) u_tmr (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(tmr_load),
    .en_i(st_q == ST_ROWW || st_q == ST_COLW), .done_o(tmr_done)
  );

  bca_col_step #(.LINE_W(LINE_W), .CW(ADDR_W), .BURST_LEN(BURST_LEN)) u_col (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(col_load), .start_i(col_start),
    .step_i(col_step), .col_o(col), .last_o(col_last)
  );

  bca_ref_ctr #(.REF_ROWS(REF_ROWS)) u_ref (
    .clk_i(clk_i), .rst_ni(rst_ni), .inc_i(ref_inc), .cnt_o(ref_cnt)
  );

  always_comb begin
    st_d      = st_q;
    tmr_load  = 1'b0;
    col_load  = 1'b0;
    col_step  = 1'b0;
    ref_inc   = 1'b0;
    cap_row   = 1'b0;
    do_commit = 1'b0;
    if (!mode_i) begin
      st_d = ST_IDLE;
    end else begin
      unique case (st_q)
        ST_IDLE: if (ras_fall) begin
          if (cas_lvl) begin
            cap_row  = 1'b1;
            tmr_load = 1'b1;
            st_d     = ST_ROWW;
          end else begin
            ref_inc = 1'b1;
            st_d    = ST_REFR;
          end
        end
        ST_ROWW: if (ras_rise) st_d = ST_IDLE;
                 else if (tmr_done) st_d = ST_ACT;
        ST_ACT: if (ras_rise) st_d = ST_IDLE;
                else if (cas_fall) begin
                  col_load = 1'b1;
                  tmr_load = 1'b1;
                  st_d     = ST_COLW;
                end
        ST_COLW: if (ras_rise) st_d = ST_IDLE;
                 else if (tmr_done) st_d = ST_BURST;
        ST_BURST: if (ras_rise) st_d = ST_IDLE;
                  else if (cas_fall) begin
                    col_step = 1'b1;
                    if (col_last) st_d = ST_DONE;
                  end
        ST_DONE: if (ras_rise) begin
          do_commit = wr_q;
          st_d      = ST_IDLE;
        end
        ST_REFR: if (ras_rise) st_d = ST_IDLE;
        default: st_d = ST_IDLE;
      endcase
    end
  end

  logic                              wr_q, bank_q, commit_q, ref_q;
  logic [ROW_W-1:0]                  row_q;
  logic [ADDR_W-1:0]                 scol_q;
  logic [DATA_W-1:0]                 dq_q;
  logic [RW-1:0]                     ref_row_q;
  logic [BURST_LEN-1:0][DATA_W-1:0]  wbuf_q;
  logic [BW-1:0]                     wptr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q      <= ST_IDLE;
      wr_q      <= 1'b0;
      bank_q    <= 1'b0;
      row_q     <= '0;
      scol_q    <= '0;
      dq_q      <= '0;
      wbuf_q    <= '0;
      wptr_q    <= '0;
      commit_q  <= 1'b0;
      ref_q     <= 1'b0;
      ref_row_q <= '0;
    end else begin
      st_q     <= st_d;
      commit_q <= do_commit;
      ref_q    <= ref_inc;
      if (ref_inc) ref_row_q <= ref_cnt;
      if (cap_row) begin
        row_q  <= addr_s[ROW_W-1:0];
        wr_q   <= ~lwe_s | ~uwe_s;
        // write: lower enable wins; read: top address bit picks the bank
        bank_q <= (~lwe_s | ~uwe_s) ? lwe_s : addr_s[ADDR_W-1];
      end
      if (col_load) begin
        scol_q <= col_start;
        wptr_q <= '0;
      end
      if (col_step) begin
        wptr_q <= wptr_q + 1'b1;
        if (wr_q) wbuf_q[wptr_q] <= dq_s;
        else      dq_q <= rdata_i;
      end
    end
  end

  assign wait_o        = !(st_q == ST_ROWW || st_q == ST_COLW);
  assign selfref_en_o  = ~mode_i;
  assign dq_oe_o       = mode_i & ~wr_q & ~re_ni & (st_q == ST_BURST || st_q == ST_DONE);
  assign dq_o          = dq_q;
  assign rd_bank_o     = bank_q;
  assign rd_row_o      = row_q;
  assign rd_col_o      = col;
  assign commit_o      = commit_q;
  assign commit_bank_o = bank_q;
  assign commit_row_o  = row_q;
  assign commit_col_o  = scol_q;
  assign commit_data_o = wbuf_q;
  assign ref_o         = ref_q;
  assign ref_row_o     = ref_row_q;

  assert_commit_src_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_o |-> ($past(st_q) == ST_DONE && $past(wr_q)));
  assert_ref_state_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ref_o |-> ($past(st_q) == ST_IDLE && st_q == ST_REFR));
  assert_mode_idle_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mode_i |=> (st_q == ST_IDLE));
  assert_colw_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_COLW) |=> $stable(col));
  assert_oe_rd_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dq_oe_o |-> !commit_o);
endmodule

// File: tb/bca_burst_ctrl_test.sv
module bca_burst_ctrl_test;
  localparam int WAITC = 4;
  localparam int LINE  = 768;
  localparam int ROWS  = 290;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic mode = 1'b0, ras = 1'b1, cas = 1'b1, lwe = 1'b1, uwe = 1'b1, re = 1'b1;
  logic [9:0] addr = '0;
  logic [11:0] dq = '0;
  logic [11:0] dq_o, rdata;
  logic dq_oe, wait_o, selfref, rd_bank, commit, cbank, ref_o;
  logic [8:0] rd_row, crow, ref_row;
  logic [9:0] rd_col, ccol;
  logic [95:0] cdata;
  int errors = 0, checks = 0;
  bit done = 0;

  always #5 clk = ~clk;

  function automatic logic [11:0] rdfn(int b, int r, int c);
    return 12'((b << 11) ^ (r * 37) ^ (c * 5));
  endfunction
  assign rdata = rdfn(int'(rd_bank), int'(rd_row), int'(rd_col));

  bca_burst_ctrl uut (
    .clk_i(clk), .rst_ni(rst_ni), .mode_i(mode), .ras_ni(ras), .cas_ni(cas),
    .addr_i(addr), .lwe_ni(lwe), .uwe_ni(uwe), .re_ni(re), .dq_i(dq),
    .dq_o(dq_o), .dq_oe_o(dq_oe), .wait_o(wait_o), .selfref_en_o(selfref),
    .rd_bank_o(rd_bank), .rd_row_o(rd_row), .rd_col_o(rd_col), .rdata_i(rdata),
    .commit_o(commit), .commit_bank_o(cbank), .commit_row_o(crow),
    .commit_col_o(ccol), .commit_data_o(cdata), .ref_o(ref_o), .ref_row_o(ref_row)
  );

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference model
  int ph = 0, wcnt = 0, beat = 0, col = 0, scol = 0, row = 0, bank = 0, refc = 0;
  bit wr = 0;
  bit h1_ras = 1, h2_ras = 1, h1_cas = 1, h2_cas = 1, h1_lwe = 1, h1_uwe = 1;
  logic [9:0] h1_addr = '0;
  logic [11:0] h1_dq = '0, e_dq = '0;
  logic [11:0] wb [8];
  bit e_ref = 0, e_commit = 0;
  int e_refrow = 0;
  int n_commit = 0;

  always @(posedge clk) begin
    bit rf, rr, cf;
    if (!rst_ni) begin
      ph = 0; refc = 0; e_dq = '0; e_ref = 0; e_commit = 0;
      h1_ras = 1; h2_ras = 1; h1_cas = 1; h2_cas = 1; h1_lwe = 1; h1_uwe = 1;
    end else begin
      rf = h2_ras & !h1_ras;
      rr = !h2_ras & h1_ras;
      cf = h2_cas & !h1_cas;
      e_ref = 0; e_commit = 0;
      if (!mode) ph = 0;
      else case (ph)
        0: if (rf) begin
             if (h1_cas) begin
               row = int'(h1_addr[8:0]);
               wr = !h1_lwe || !h1_uwe;
               bank = wr ? int'(h1_lwe) : int'(h1_addr[9]);
               wcnt = WAITC - 1; ph = 1;
             end else begin
               e_ref = 1; e_refrow = refc; refc = (refc + 1) % ROWS; ph = 6;
             end
           end
        1, 3: if (rr) ph = 0;
              else if (wcnt == 0) begin ph = ph + 1; beat = 0; end
              else wcnt--;
        2: if (rr) ph = 0;
           else if (cf) begin
             col = int'(h1_addr) % LINE; scol = col; wcnt = WAITC - 1; ph = 3;
           end
        4: if (rr) ph = 0;
           else if (cf) begin
             if (wr) wb[beat] = h1_dq; else e_dq = rdfn(bank, row, col);
             col = (col + 1) % LINE;
             if (beat == 7) ph = 5; else beat++;
           end
        5: if (rr) begin e_commit = wr; ph = 0; end
        default: if (rr) ph = 0;
      endcase
      h2_ras = h1_ras; h1_ras = ras; h2_cas = h1_cas; h1_cas = cas;
      h1_lwe = lwe; h1_uwe = uwe; h1_addr = addr; h1_dq = dq;
    end
    #2;
    if (rst_ni && !done) begin
      chk(wait_o === !(ph == 1 || ph == 3), "R2 wait", wait_o, !(ph == 1 || ph == 3));
      chk(selfref === !mode, "R9 selfref", selfref, !mode);
      chk(dq_oe === (mode && !wr && !re && (ph == 4 || ph == 5)), "R6 dq_oe", dq_oe,
          mode && !wr && !re && (ph == 4 || ph == 5));
      chk(dq_o === e_dq, "R5 read word", dq_o, e_dq);
      chk(ref_o === e_ref, "R8 ref pulse", ref_o, e_ref);
      if (e_ref) chk(ref_row === 9'(e_refrow), "R8 ref row", ref_row, e_refrow);
      chk(commit === e_commit, "R7 commit pulse", commit, e_commit);
      if (e_commit) begin
        n_commit++;
        chk(cbank === 1'(bank), "R4 commit bank", cbank, bank);
        chk(crow === 9'(row), "R7 commit row", crow, row);
        chk(ccol === 10'(scol), "R3 commit col", ccol, scol);
        for (int i = 0; i < 8; i++)
          chk(cdata[i*12 +: 12] === wb[i], "R3/R10 commit word", cdata[i*12 +: 12], wb[i]);
      end
    end
  end

  task automatic tk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic burst(input bit lw, input bit uw, input logic [9:0] r, input logic [9:0] c,
                       input int seed, input int beats, input bit glitch);
    addr = r; lwe = lw; uwe = uw; tk(1);
    ras = 1'b0; tk(WAITC + 4);
    lwe = 1'b1; uwe = 1'b1; addr = c; cas = 1'b0;
    if (glitch) begin tk(1); cas = 1'b1; tk(1); cas = 1'b0; end
    tk(WAITC + 4);
    for (int i = 0; i < beats; i++) begin
      cas = 1'b1; dq = 12'(seed + i * 3); tk(2);
      cas = 1'b0; tk(2);
    end
    cas = 1'b1; tk(1); re = 1'b1; tk(2);
    ras = 1'b1; tk(4);
  endtask

  task automatic refresh(input logic [9:0] a);
    cas = 1'b0; tk(2);
    addr = a; ras = 1'b0; tk(3);
    ras = 1'b1; tk(2);
    cas = 1'b1; tk(2);
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      done = 1;
      errors++; checks++;
      $display("FAIL watchdog R1 actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    tk(3);
    // R1 reset state
    chk(wait_o === 1'b1, "R1 wait", wait_o, 1);
    chk(dq_oe === 1'b0, "R1 dq_oe", dq_oe, 0);
    chk(commit === 1'b0, "R1 commit", commit, 0);
    chk(ref_o === 1'b0, "R1 ref", ref_o, 0);
    rst_ni = 1'b1; tk(2);
    mode = 1'b1; tk(2);
    re = 1'b0;
    burst(1'b0, 1'b1, 10'h005, 10'd3,   100, 8, 1'b0);   // R4 lower bank
    burst(1'b1, 1'b0, 10'h20A, 10'd766, 200, 8, 1'b0);   // R4 upper bank, R3 wrap
    burst(1'b0, 1'b0, 10'h011, 10'd900, 300, 8, 1'b0);   // R4 both low, R3 modulo
    burst(1'b0, 1'b1, 10'h012, 10'd40,  400, 3, 1'b0);   // R7 cut short
    burst(1'b1, 1'b0, 10'h013, 10'd50,  500, 8, 1'b1);   // R10 glitch in column wait
    re = 1'b0;
    burst(1'b1, 1'b1, 10'h003, 10'd10,  0, 8, 1'b0);     // R5 bank 0 read
    re = 1'b0;
    burst(1'b1, 1'b1, 10'h203, 10'd765, 0, 8, 1'b0);     // R5 bank 1 read, wrap
    re = 1'b0;
    burst(1'b1, 1'b1, 10'h004, 10'd20,  0, 5, 1'b1);     // R10 read, short
    for (int i = 0; i < 295; i++) refresh(10'(i * 7));   // R8 wrap past 289
    mode = 1'b0; tk(2);                                  // R9 ignored strobes
    burst(1'b0, 1'b1, 10'h006, 10'd5, 600, 8, 1'b0);
    refresh(10'h3FF);
    mode = 1'b1; tk(2);
    burst(1'b0, 1'b1, 10'h007, 10'd6, 700, 8, 1'b0);
    chk(n_commit == 5, "R7 commit count", n_commit, 5);
    tk(4);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule